// File: doc/BRIEF.md
# Boundary Scan Test Access Block

This block is the test access port of a device. A four-wire serial port carries a mode select, data in and data out, with an optional active-low reset. Through that port, test equipment drives a sixteen-state controller. The controller selects an instruction and then moves data through one of three serial registers: a one-bit pass-through, a 32-bit identification word, or a chain of boundary cells that sits between the core logic and the pads. In normal operation the core's outputs, output enables and inputs pass straight through the cells. Under the external-test instruction the pads are driven from values that were shifted in earlier.

A status input reports whether the device holds a valid configuration. While that input is low, a global pad enable stays off: every pad driver is disabled and the input buffers feed zeros to the core. The boundary chain can still capture, shift and update in this state. The values it updates take effect on the pads only once the status input goes high.

Top module: `jtag_scan_top`

## Requirements
- R1: The controller advances on each rising edge of `tck` according to `tms`. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Reaching that state selects the identification instruction and returns the pads to normal pass-through.
- R2: While `trst_n` is low, the controller is held in Test-Logic-Reset without any clock edge, and the instruction reverts to the identification instruction. The first data shift after reset then returns the 32-bit identification word.
- R3: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 4'b0001, so the bits leave as 1,0,0,0. The opcodes are external test 4'b0000, sample/preload 4'b0001, identification 4'b0010 and bypass 4'b1111. Every other opcode behaves as bypass.
- R4: Under bypass, the data path is a single stage. It captures 0, and each bit shifted in on `tdi` appears on `tdo` one shift later.
- R5: The identification word, read least significant bit first, is bit 0 = 1, bits 11:1 = manufacturer code (`ID_MFR`), bits 27:12 = part number (`ID_PART`) and bits 31:28 = version (`ID_VERSION`).
- R6: The boundary chain holds three cells per I/O *i*, and bit 0 leaves first. Bit 3*i* is the input cell and captures the gated pad input. Bit 3*i*+1 is the output cell and captures `core_out[i]`. Bit 3*i*+2 is the enable cell and captures `core_oe[i]`. Capture happens in Capture-DR under both the sample/preload and the external-test instruction.
- R7: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is high only during Shift-IR and Shift-DR, and it is low after reset.
- R8: Under external test, `pad_out[i]` carries the updated output cell and `pad_oe[i]` carries the updated enable cell, gated by the global enable.
- R9: Under any other instruction, `pad_out` equals `core_out` and `pad_oe` equals `core_oe` gated by the global enable. Sample/preload therefore leaves the pads unchanged.
- R10: While `programmed` is low, `pad_oe` and `core_in` are all zero and the input cells capture 0. The boundary chain still shifts and updates.
- R11: The boundary update latches load on the falling edge in Update-DR, and only when a boundary instruction is selected. Instruction shifts and bypass shifts leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on the falling edge |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| programmed | input | 1 | Device holds a valid configuration; gates the global pad enable |
| core_out | input | NUM_IO | Output data from the core |
| core_oe | input | NUM_IO | Output enables from the core |
| core_in | output | NUM_IO | Pad inputs delivered to the core |
| pad_in | input | NUM_IO | Values present at the pads |
| pad_out | output | NUM_IO | Data to the pad drivers |
| pad_oe | output | NUM_IO | Enables of the pad drivers |

## Verification
Three kinds of serial pattern are applied to the data path. Alternating and irregular bit streams under bypass and under an unused opcode separate a one-stage delay from a longer chain or a wrong opcode decode. Distinct patterns on the core outputs, enables and pad inputs are captured into the boundary chain, and each I/O uses a different combination so that a swapped cell or a wrong cell order shows up on `tdo`. Preloaded patterns are then driven under external test with the configuration status both low and high, and unrelated instruction and bypass shifts are placed between preload and drive. Together these tell pass-through from external drive, show that a stray update is caught, and separate the gating of the global enable from the shifting of the chain.

// File: rtl/jtag_scan_pkg.sv
`timescale 1ns/1ps
package jtag_scan_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_EX2_DR   = 4'h0,
        ST_EX1_DR   = 4'h1,
        ST_SHIFT_DR = 4'h2,
        ST_PAUSE_DR = 4'h3,
        ST_SEL_IR   = 4'h4,
        ST_UPD_DR   = 4'h5,
        ST_CAP_DR   = 4'h6,
        ST_SEL_DR   = 4'h7,
        ST_EX2_IR   = 4'h8,
        ST_EX1_IR   = 4'h9,
        ST_SHIFT_IR = 4'hA,
        ST_PAUSE_IR = 4'hB,
        ST_IDLE     = 4'hC,
        ST_UPD_IR   = 4'hD,
        ST_CAP_IR   = 4'hE,
        ST_RESET    = 4'hF
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [1:0] {
        DR_BYPASS,
        DR_IDENT,
        DR_BOUNDARY
    } dr_sel_e;

endpackage

// File: rtl/jtag_tap_fsm.sv
`timescale 1ns/1ps
module jtag_tap_fsm
    import jtag_scan_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    typedef struct packed {
        tap_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_RESET:    fsm_d.st = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   fsm_d.st = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   fsm_d.st = tms ? ST_EX1_DR   : ST_SHIFT_DR;
            ST_SHIFT_DR: fsm_d.st = tms ? ST_EX1_DR   : ST_SHIFT_DR;
            ST_EX1_DR:   fsm_d.st = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: fsm_d.st = tms ? ST_EX2_DR   : ST_PAUSE_DR;
            ST_EX2_DR:   fsm_d.st = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   fsm_d.st = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   fsm_d.st = tms ? ST_EX1_IR   : ST_SHIFT_IR;
            ST_SHIFT_IR: fsm_d.st = tms ? ST_EX1_IR   : ST_SHIFT_IR;
            ST_EX1_IR:   fsm_d.st = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: fsm_d.st = tms ? ST_EX2_IR   : ST_PAUSE_IR;
            ST_EX2_IR:   fsm_d.st = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   fsm_d.st = tms ? ST_SEL_DR   : ST_IDLE;
            default:     fsm_d.st = ST_RESET;
        endcase
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) fsm_q <= '{st: ST_RESET};
        else         fsm_q <= fsm_d;
    end

    assign state = fsm_q.st;

endmodule

// File: rtl/jtag_instr_reg.sv
`timescale 1ns/1ps
module jtag_instr_reg
    import jtag_scan_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic            ir_lsb,
    output logic [IR_W-1:0] instr
);

    typedef struct packed {
        logic [IR_W-1:0] sr;
    } shift_t;

    typedef struct packed {
        logic [IR_W-1:0] op;
    } hold_t;

    shift_t sh_d, sh_q;
    hold_t  hd_d, hd_q;

    always_comb begin
        sh_d = sh_q;
        hd_d = hd_q;
        if (state == ST_CAP_IR)   sh_d.sr = IR_CAPTURE;
        if (state == ST_SHIFT_IR) sh_d.sr = {tdi, sh_q.sr[IR_W-1:1]};
        if (state == ST_RESET)    hd_d.op = OP_IDCODE;
        if (state == ST_UPD_IR)   hd_d.op = sh_q.sr;
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sh_q <= '{sr: IR_CAPTURE};
        else         sh_q <= sh_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) hd_q <= '{op: OP_IDCODE};
        else         hd_q <= hd_d;
    end

    assign ir_lsb = sh_q.sr[0];
    assign instr  = hd_q.op;

endmodule

// File: rtl/jtag_boundary_chain.sv
`timescale 1ns/1ps
module jtag_boundary_chain
    import jtag_scan_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input  logic              tck,
    input  logic              trst_n,
    input  tap_state_e        state,
    input  logic              tdi,
    input  logic              selected,
    input  logic              io_en,
    input  logic [NUM_IO-1:0] core_out,
    input  logic [NUM_IO-1:0] core_oe,
    input  logic [NUM_IO-1:0] pad_in,
    output logic              chain_lsb,
    output logic [NUM_IO-1:0] upd_out,
    output logic [NUM_IO-1:0] upd_oe
);

    localparam int CELLS_PER_IO = 3;
    localparam int CHAIN_W      = CELLS_PER_IO * NUM_IO;

    typedef struct packed {
        logic [CHAIN_W-1:0] sr;
    } shift_t;

    typedef struct packed {
        logic [NUM_IO-1:0] dout;
        logic [NUM_IO-1:0] doe;
    } hold_t;

    logic [CHAIN_W-1:0] cap_vec;
    logic [NUM_IO-1:0]  sr_out_cells;
    logic [NUM_IO-1:0]  sr_oe_cells;

    shift_t sh_d, sh_q;
    hold_t  hd_d, hd_q;

    for (genvar i = 0; i < NUM_IO; i++) begin : g_cell
        assign cap_vec[CELLS_PER_IO*i]     = pad_in[i] & io_en;
        assign cap_vec[CELLS_PER_IO*i + 1] = core_out[i];
        assign cap_vec[CELLS_PER_IO*i + 2] = core_oe[i];
        assign sr_out_cells[i]             = sh_q.sr[CELLS_PER_IO*i + 1];
        assign sr_oe_cells[i]              = sh_q.sr[CELLS_PER_IO*i + 2];
    end

    always_comb begin
        sh_d = sh_q;
        hd_d = hd_q;
        if (selected) begin
            if (state == ST_CAP_DR)   sh_d.sr = cap_vec;
            if (state == ST_SHIFT_DR) sh_d.sr = {tdi, sh_q.sr[CHAIN_W-1:1]};
            if (state == ST_UPD_DR) begin
                hd_d.dout = sr_out_cells;
                hd_d.doe  = sr_oe_cells;
            end
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) hd_q <= '0;
        else         hd_q <= hd_d;
    end

    assign chain_lsb = sh_q.sr[0];
    assign upd_out   = hd_q.dout;
    assign upd_oe    = hd_q.doe;

endmodule

// File: rtl/jtag_scan_top.sv
`timescale 1ns/1ps
module jtag_scan_top
    import jtag_scan_pkg::*;
#(
    parameter int          NUM_IO     = 4,
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'hA5C1,
    parameter logic [10:0] ID_MFR     = 11'h1B7
) (
    input  logic              tck,
    input  logic              trst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    output logic              tdo_oe,
    input  logic              programmed,
    input  logic [NUM_IO-1:0] core_out,
    input  logic [NUM_IO-1:0] core_oe,
    output logic [NUM_IO-1:0] core_in,
    input  logic [NUM_IO-1:0] pad_in,
    output logic [NUM_IO-1:0] pad_out,
    output logic [NUM_IO-1:0] pad_oe
);

    localparam int          ID_W     = 32;
    localparam logic [31:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

    typedef struct packed {
        logic [ID_W-1:0] ident;
        logic            byp;
    } dreg_t;

    typedef struct packed {
        logic tdo;
        logic oe;
    } out_t;

    tap_state_e        tap_state;
    logic [IR_W-1:0]   instr;
    logic              ir_lsb;
    logic              chain_lsb;
    logic [NUM_IO-1:0] upd_out;
    logic [NUM_IO-1:0] upd_oe;
    dr_sel_e           dr_sel;
    logic              extest;
    logic              in_shift;
    logic              dr_bit;

    dreg_t dr_d, dr_q;
    out_t  ot_d, ot_q;

    jtag_tap_fsm i_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (tap_state)
    );

    jtag_instr_reg i_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (tap_state),
        .tdi    (tdi),
        .ir_lsb (ir_lsb),
        .instr  (instr)
    );

    always_comb begin
        unique case (instr)
            OP_EXTEST, OP_SAMPLE: dr_sel = DR_BOUNDARY;
            OP_IDCODE:            dr_sel = DR_IDENT;
            default:              dr_sel = DR_BYPASS;
        endcase
    end

    assign extest = (instr == OP_EXTEST);

    jtag_boundary_chain #(.NUM_IO(NUM_IO)) i_bsr (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (tap_state),
        .tdi       (tdi),
        .selected  (dr_sel == DR_BOUNDARY),
        .io_en     (programmed),
        .core_out  (core_out),
        .core_oe   (core_oe),
        .pad_in    (pad_in),
        .chain_lsb (chain_lsb),
        .upd_out   (upd_out),
        .upd_oe    (upd_oe)
    );

    // identification and bypass stages, rising edge
    always_comb begin
        dr_d = dr_q;
        if (tap_state == ST_CAP_DR) begin
            if (dr_sel == DR_IDENT)  dr_d.ident = ID_VALUE;
            if (dr_sel == DR_BYPASS) dr_d.byp   = 1'b0;
        end
        if (tap_state == ST_SHIFT_DR) begin
            if (dr_sel == DR_IDENT)  dr_d.ident = {tdi, dr_q.ident[ID_W-1:1]};
            if (dr_sel == DR_BYPASS) dr_d.byp   = tdi;
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) dr_q <= '{ident: ID_VALUE, byp: 1'b0};
        else         dr_q <= dr_d;
    end

    // serial output stage, falling edge
    always_comb begin
        unique case (dr_sel)
            DR_BOUNDARY: dr_bit = chain_lsb;
            DR_IDENT:    dr_bit = dr_q.ident[0];
            default:     dr_bit = dr_q.byp;
        endcase
        in_shift = (tap_state == ST_SHIFT_DR) || (tap_state == ST_SHIFT_IR);
        ot_d.oe  = in_shift;
        ot_d.tdo = (tap_state == ST_SHIFT_IR) ? ir_lsb : dr_bit;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) ot_q <= '0;
        else         ot_q <= ot_d;
    end

    assign tdo     = ot_q.tdo;
    assign tdo_oe  = ot_q.oe;

    // pad multiplexing under the global enable
    assign pad_out = extest ? upd_out : core_out;
    assign pad_oe  = {NUM_IO{programmed}} & (extest ? upd_oe : core_oe);
    assign core_in = {NUM_IO{programmed}} & pad_in;

endmodule

// File: rtl/jtag_scan_chk.sv
`timescale 1ns/1ps
module jtag_scan_chk
    import jtag_scan_pkg::*;
#(
    parameter int NUM_IO = 4
) (
    input logic              tck,
    input logic              trst_n,
    input logic              tms,
    input logic              programmed,
    input logic              tdo_oe,
    input tap_state_e        tap_state,
    input logic [IR_W-1:0]   instr,
    input logic [NUM_IO-1:0] core_out,
    input logic [NUM_IO-1:0] core_oe,
    input logic [NUM_IO-1:0] core_in,
    input logic [NUM_IO-1:0] pad_out,
    input logic [NUM_IO-1:0] pad_oe
);

    logic [2:0] high_run;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)           high_run <= '0;
        else if (!tms)         high_run <= '0;
        else if (high_run < 5) high_run <= high_run + 3'd1;
    end

    assert_five_high_resets_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (high_run >= 3'd5) |-> (tap_state == ST_RESET));

    assert_reset_selects_ident_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_state == ST_RESET) |=> (instr == OP_IDCODE));

    assert_tdo_only_in_shift_R7: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (tap_state == ST_SHIFT_DR || tap_state == ST_SHIFT_IR));

    assert_pass_through_R9: assert property (@(posedge tck) disable iff (!trst_n)
        (programmed && instr != OP_EXTEST) |-> (pad_out == core_out && pad_oe == core_oe));

    assert_pads_off_R10: assert property (@(posedge tck) disable iff (!trst_n)
        !programmed |-> (pad_oe == '0 && core_in == '0));

endmodule

bind jtag_scan_top jtag_scan_chk #(.NUM_IO(NUM_IO)) i_chk (
    .tck        (tck),
    .trst_n     (trst_n),
    .tms        (tms),
    .programmed (programmed),
    .tdo_oe     (tdo_oe),
    .tap_state  (tap_state),
    .instr      (instr),
    .core_out   (core_out),
    .core_oe    (core_oe),
    .core_in    (core_in),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe)
);

// File: tb/test_jtag_scan_top.sv
`timescale 1ns/1ps
module test_jtag_scan_top;

    localparam int          NIO    = 4;
    localparam logic [31:0] IDWORD = {4'h3, 16'hA5C1, 11'h1B7, 1'b1};

    logic           tck = 1'b0;
    logic           trst_n, tms, tdi, programmed;
    logic           tdo, tdo_oe;
    logic [NIO-1:0] core_out, core_oe, core_in, pad_in, pad_out, pad_oe;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic  exp_q[$];
    string req_q[$];

    always #5 tck = ~tck;

    jtag_scan_top #(.NUM_IO(NIO)) i_jtag_scan_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .programmed(programmed), .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares every bit presented on tdo while it is driven
    initial begin
        forever begin
            @(negedge tck);
            #3;
            if (tdo_oe === 1'b1) begin
                if (exp_q.size() == 0) chk("R7 unexpected drive", 1, 0);
                else chk(req_q.pop_front(), {63'd0, tdo}, {63'd0, exp_q.pop_front()});
            end
        end
    end

    function automatic logic [63:0] cells(logic [NIO-1:0] i_in, logic [NIO-1:0] i_out,
                                          logic [NIO-1:0] i_oe);
        logic [63:0] v = '0;
        for (int i = 0; i < NIO; i++) begin
            v[3*i]     = i_in[i];
            v[3*i + 1] = i_out[i];
            v[3*i + 2] = i_oe[i];
        end
        return v;
    endfunction

    task automatic step(logic m, logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic push(logic b, string req);
        exp_q.push_back(b);
        req_q.push_back(req);
    endtask

    task automatic shift_ir(logic [3:0] op);
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge tck); #1;
            push(4'b0001 >> i, "R3 ir capture");
            tms = (i == 3); tdi = op[i];
        end
        step(1, 0); step(0, 0);
    endtask

    task automatic shift_dr(int n, logic [63:0] din, logic [63:0] exp, string req);
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < n; i++) begin
            @(negedge tck); #1;
            push(exp[i], req);
            tms = (i == n - 1); tdi = din[i];
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        logic [63:0] p1, p2, p3;
        trst_n = 0; tms = 1; tdi = 0; programmed = 1;
        core_out = 4'b1010; core_oe = 4'b1100; pad_in = 4'b0110;
        p1 = cells(4'b0000, 4'b0101, 4'b0011);
        p2 = cells(4'b1111, 4'b1001, 4'b0110);
        p3 = cells(4'b0000, 4'b0111, 4'b1110);
        #23;
        chk("R7 oe after reset", tdo_oe, 0);
        chk("R9 pad_out reset", pad_out, core_out);
        chk("R9 pad_oe reset", pad_oe, core_oe);
        chk("R10 core_in programmed", core_in, pad_in);
        trst_n = 1;
        step(0, 0);
        step(0, 0);
        chk("R7 oe idle", tdo_oe, 0);

        // R2 / R5: identification selected after reset
        shift_dr(32, 64'h0, {32'h0, IDWORD}, "R5 idcode");

        // R4: bypass delays by one
        shift_ir(4'b1111);
        shift_dr(8, 64'hB2, {56'h0, 8'hB2} << 1, "R4 bypass");

        // R3: unused opcode behaves as bypass
        shift_ir(4'b0101);
        shift_dr(4, 64'hD, 64'hA, "R3 unused opcode");

        // R6 / R9: sample captures pins, preloads p1, pads untouched
        shift_ir(4'b0001);
        chk("R9 sample pad_out", pad_out, core_out);
        shift_dr(12, p1, cells(pad_in, core_out, core_oe), "R6 sample capture");
        chk("R9 sample pad_oe", pad_oe, core_oe);

        // R8 / R11: external test drives the preloaded values
        shift_ir(4'b0000);
        chk("R8 extest pad_out p1", pad_out, 4'b0101);
        chk("R11 extest pad_oe p1", pad_oe, 4'b0011);
        shift_dr(12, p2, cells(pad_in, core_out, core_oe), "R6 extest capture");
        chk("R8 extest pad_out p2", pad_out, 4'b1001);
        chk("R8 extest pad_oe p2", pad_oe, 4'b0110);

        // R10: unprogrammed device keeps pads off but still shifts
        programmed = 0;
        #1;
        chk("R10 pad_oe off", pad_oe, 0);
        chk("R10 core_in off", core_in, 0);
        shift_dr(12, p3, cells(4'b0000, core_out, core_oe), "R10 capture gated");
        chk("R10 pad_oe still off", pad_oe, 0);
        chk("R10 pad_out updated", pad_out, 4'b0111);
        programmed = 1;
        #1;
        chk("R10 update kept", pad_oe, 4'b1110);

        // R11: instruction and bypass shifts leave update latches alone
        shift_ir(4'b1111);
        shift_dr(4, 64'h5, 64'hA, "R4 bypass second");
        shift_ir(4'b0000);
        chk("R11 latches held out", pad_out, 4'b0111);
        chk("R11 latches held oe", pad_oe, 4'b1110);

        // R1: five tms-high edges from inside Shift-DR
        step(1, 0); step(0, 0); step(0, 0);
        @(negedge tck); #1;
        push(pad_in[0], "R1 first bit");
        tms = 1;
        for (int k = 0; k < 4; k++) step(1, 0);
        step(0, 0);
        chk("R1 pads normal", pad_out, core_out);
        chk("R7 oe off after reset path", tdo_oe, 0);
        shift_dr(32, 64'h0, {32'h0, IDWORD}, "R1 idcode after tms reset");

        // R2: asynchronous reset from idle with bypass loaded
        shift_ir(4'b1111);
        #2;
        trst_n = 0;
        #2;
        chk("R2 pads normal in reset", pad_oe, core_oe);
        trst_n = 1;
        step(0, 0);
        shift_dr(32, 64'h0, {32'h0, IDWORD}, "R2 idcode after trst");

        repeat (3) @(negedge tck);
        #4;
        chk("R7 queue drained", exp_q.size(), 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule